// File: doc/BRIEF.md
# Sized Flag ALU

A combinational integer unit that produces a 64-bit result, a write strobe and an updated N/Z/C/V flag set for one operation. It covers addition and subtraction with and without incoming carry, comparison, bitwise AND/OR/XOR, increment, decrement, negation, plain moves, and moves or sets guarded by one of eight flag conditions. An execute stage places it between operand fetch and writeback. It supplies the destination and source values, the instruction's byte-size field, whether the destination lives in memory, and the current flags. It then commits `result_o` when `we_o` is high and always latches `flags_o`.

The sign bit used for N and V moves with the effective operand width, while the zero test always looks at the whole 64-bit result. For arithmetic and logic, a register destination always works on 8 bytes. A memory destination works on size+1 bytes, capped at 8. Moves take their width from the size field alone.

Top module: `sized_flag_alu`

## Requirements
- R1: Effective width k in bytes: for opcodes 0..10, k is 8 when `dst_mem_i` is 0 and min(`size_i`+1, 8) when it is 1. For moves (opcode 11 and taken conditional moves), k is min(`size_i`+1, 8). N is bit 8k-1 of the result. `flags_i`/`flags_o` bit positions are [3]=N, [2]=Z, [1]=C, [0]=V.
- R2: Opcodes: 0 add (dst+src), 1 add-with-carry (dst+src+C), 2 subtract (dst+~src+1), 3 subtract-with-borrow (dst+~src+C). `result_o` is the unmasked 64-bit sum and `we_o` is 1.
- R3: For opcodes 0..4, C is set exactly when the 64-bit sum is unsigned-less-than the second addend (src or ~src).
- R4: For opcodes 0..4, V is set when dst and the second addend differ at bit 8k-1 and the sum differs from dst at that bit.
- R5: Whenever Z is updated, it is set exactly when the full 64-bit result is zero, regardless of k.
- R6: Opcode 4 (compare) updates N, Z, C and V exactly as subtract does. `we_o` is 0, and `result_o` carries the difference.
- R7: Opcodes 5 AND, 6 OR, 7 XOR, 8 increment (dst+1), 9 decrement (dst-1) and 10 negate (0-dst) write their result and update only N and Z. C and V pass through unchanged.
- R8: Opcode 11 (move) writes src with bytes at and above k cleared, sets Z and N from that value, and keeps C and V.
- R9: Opcodes 16..23 are conditional moves with condition code op[2:0]. op[2:1] selects the flag: 0 N, 1 C, 2 Z, 3 V. op[0]=0 means "flag set" and op[0]=1 means "flag clear". When the condition holds, the operation behaves as R8.
- R10: A conditional move whose condition fails drives `we_o` 0, passes `dst_i` to `result_o`, and leaves all four flags unchanged.
- R11: Opcodes 24..31 write 1 when condition op[2:0] (as in R9) holds and 0 otherwise, with `we_o` 1 and flags unchanged.
- R12: Opcodes 12..15 drive `we_o` 0, pass `dst_i` to `result_o`, and leave the flags unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code |
| dst_i | input | 64 | Destination operand value |
| src_i | input | 64 | Source operand value |
| size_i | input | 4 | Byte-size field (value+1 bytes, capped at 8) |
| dst_mem_i | input | 1 | Destination is a memory location |
| flags_i | input | 4 | Current flags {N,Z,C,V} |
| result_o | output | 64 | Result value |
| we_o | output | 1 | Result is to be written back |
| flags_o | output | 4 | Updated flags {N,Z,C,V} |

## Verification
The bench builds the block with its defaults: a 64-bit datapath and a 4-bit size field. Because the size field can exceed 7, the capping of the width to 8 bytes is reachable alongside every narrower width. Random opcodes across all 32 codes, random sizes and both destination kinds put the sign bit at each byte boundary. Directed cases hit carry and overflow edges, wide results that are zero only above the narrow width, and failed conditional moves.

// File: rtl/alu_pkg.sv
package alu_pkg;
  localparam logic [4:0] OP_ADD = 5'd0;
  localparam logic [4:0] OP_ADC = 5'd1;
  localparam logic [4:0] OP_SUB = 5'd2;
  localparam logic [4:0] OP_SBC = 5'd3;
  localparam logic [4:0] OP_CMP = 5'd4;
  localparam logic [4:0] OP_AND = 5'd5;
  localparam logic [4:0] OP_OR  = 5'd6;
  localparam logic [4:0] OP_XOR = 5'd7;
  localparam logic [4:0] OP_INC = 5'd8;
  localparam logic [4:0] OP_DEC = 5'd9;
  localparam logic [4:0] OP_NEG = 5'd10;
  localparam logic [4:0] OP_MOV = 5'd11;

  localparam int FL_N = 3;
  localparam int FL_Z = 2;
  localparam int FL_C = 1;
  localparam int FL_V = 0;
endpackage

// File: rtl/alu_width.sv
module alu_width #(
  parameter int BYTES  = 8,
  parameter int SIZE_W = 4,
  parameter int IDX_W  = $clog2(8 * BYTES)
) (
  input  logic [SIZE_W-1:0]  size_i,
  input  logic               full_i,
  output logic [8*BYTES-1:0] mask_o,
  output logic [IDX_W-1:0]   sign_idx_o
);
  localparam int NB_W = $clog2(BYTES) + 1;
  logic [NB_W-1:0] nbytes;

  always_comb begin
    if (full_i || int'(size_i) >= BYTES - 1) nbytes = NB_W'(BYTES);
    else                                     nbytes = NB_W'(int'(size_i) + 1);
    sign_idx_o = IDX_W'(8 * int'(nbytes) - 1);
  end

  for (genvar j = 0; j < BYTES; j++) begin : g_byte
    assign mask_o[8*j +: 8] = {8{int'(nbytes) > j}};
  end

  // R1: mask is a contiguous run of whole low bytes, never empty
  always_comb begin
    a_r1_mask_contiguous: assert (mask_o[7:0] == 8'hFF && ((mask_o + 1'b1) & mask_o) == '0);
  end
endmodule

// File: rtl/alu_adder.sv
module alu_adder #(
  parameter int DATA_W = 64,
  parameter int IDX_W  = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              cin_i,
  input  logic [IDX_W-1:0]  sign_idx_i,
  output logic [DATA_W-1:0] sum_o,
  output logic              carry_o,
  output logic              ovf_o
);
  logic [DATA_W-1:0] ab_diff, as_diff;

  always_comb begin
    sum_o   = a_i + b_i + {{(DATA_W-1){1'b0}}, cin_i};
    carry_o = sum_o < b_i;
    ab_diff = a_i ^ b_i;
    as_diff = a_i ^ sum_o;
    ovf_o   = ab_diff[sign_idx_i] & as_diff[sign_idx_i];
  end
endmodule

// File: rtl/alu_cond.sv
module alu_cond
  import alu_pkg::*;
(
  input  logic [3:0] flags_i,
  input  logic [2:0] sel_i,
  output logic       hit_o
);
  logic raw;
  always_comb begin
    case (sel_i[2:1])
      2'd0:    raw = flags_i[FL_N];
      2'd1:    raw = flags_i[FL_C];
      2'd2:    raw = flags_i[FL_Z];
      default: raw = flags_i[FL_V];
    endcase
    hit_o = raw ^ sel_i[0];
  end
endmodule

// File: rtl/sized_flag_alu.sv
module sized_flag_alu
  import alu_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int SIZE_W = 4
) (
  input  logic [4:0]        op_i,
  input  logic [DATA_W-1:0] dst_i,
  input  logic [DATA_W-1:0] src_i,
  input  logic [SIZE_W-1:0] size_i,
  input  logic              dst_mem_i,
  input  logic [3:0]        flags_i,
  output logic [DATA_W-1:0] result_o,
  output logic              we_o,
  output logic [3:0]        flags_o
);
  localparam int BYTES = DATA_W / 8;
  localparam int IDX_W = $clog2(DATA_W);

  logic [DATA_W-1:0] arith_mask, mov_mask;
  logic [IDX_W-1:0]  arith_idx, mov_idx;
  logic [DATA_W-1:0] add_b, sum;
  logic              add_cin, carry, ovf, hit;
  logic [DATA_W-1:0] logic_res, mov_res;

  alu_width #(.BYTES(BYTES), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_arith_w (
    .size_i(size_i), .full_i(~dst_mem_i), .mask_o(arith_mask), .sign_idx_o(arith_idx)
  );

  alu_width #(.BYTES(BYTES), .SIZE_W(SIZE_W), .IDX_W(IDX_W)) u_mov_w (
    .size_i(size_i), .full_i(1'b0), .mask_o(mov_mask), .sign_idx_o(mov_idx)
  );

  always_comb begin
    add_b   = src_i;
    add_cin = 1'b0;
    case (op_i)
      OP_ADC:         add_cin = flags_i[FL_C];
      OP_SUB, OP_CMP: begin add_b = ~src_i; add_cin = 1'b1; end
      OP_SBC:         begin add_b = ~src_i; add_cin = flags_i[FL_C]; end
      default: ;
    endcase
  end

  alu_adder #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_add (
    .a_i(dst_i), .b_i(add_b), .cin_i(add_cin), .sign_idx_i(arith_idx),
    .sum_o(sum), .carry_o(carry), .ovf_o(ovf)
  );

  alu_cond u_cond (.flags_i(flags_i), .sel_i(op_i[2:0]), .hit_o(hit));

  always_comb begin
    case (op_i)
      OP_AND:  logic_res = dst_i & src_i;
      OP_OR:   logic_res = dst_i | src_i;
      OP_XOR:  logic_res = dst_i ^ src_i;
      OP_INC:  logic_res = dst_i + 1'b1;
      OP_DEC:  logic_res = dst_i - 1'b1;
      default: logic_res = '0 - dst_i;
    endcase
    mov_res = src_i & mov_mask;
  end

  always_comb begin
    result_o = dst_i;
    we_o     = 1'b0;
    flags_o  = flags_i;
    casez (op_i)
      OP_ADD, OP_ADC, OP_SUB, OP_SBC, OP_CMP: begin
        result_o      = sum;
        we_o          = (op_i != OP_CMP);
        flags_o[FL_N] = sum[arith_idx];
        flags_o[FL_Z] = (sum == '0);
        flags_o[FL_C] = carry;
        flags_o[FL_V] = ovf;
      end
      OP_AND, OP_OR, OP_XOR, OP_INC, OP_DEC, OP_NEG: begin
        result_o      = logic_res;
        we_o          = 1'b1;
        flags_o[FL_N] = logic_res[arith_idx];
        flags_o[FL_Z] = (logic_res == '0);
      end
      OP_MOV: begin
        result_o      = mov_res;
        we_o          = 1'b1;
        flags_o[FL_N] = mov_res[mov_idx];
        flags_o[FL_Z] = (mov_res == '0);
      end
      5'b10???: if (hit) begin
        result_o      = mov_res;
        we_o          = 1'b1;
        flags_o[FL_N] = mov_res[mov_idx];
        flags_o[FL_Z] = (mov_res == '0);
      end
      5'b11???: begin
        result_o = {{(DATA_W-1){1'b0}}, hit};
        we_o     = 1'b1;
      end
      default: ;
    endcase
  end

  always_comb begin
    if (op_i == OP_CMP)
      a_r6_cmp_no_write: assert (!we_o && flags_o[FL_Z] == (dst_i == src_i));
    if (op_i >= OP_AND && op_i <= OP_NEG)
      a_r7_logic_keeps_cv: assert (flags_o[1:0] == flags_i[1:0]);
    if (op_i == OP_MOV)
      a_r8_mov_high_clear: assert ((result_o & ~mov_mask) == '0);
    if (op_i[4:3] == 2'b10 && !we_o)
      a_r10_cmov_fail_quiet: assert (result_o == dst_i && flags_o == flags_i);
    if (op_i <= OP_MOV && op_i != OP_CMP)
      a_r5_zero_full_word: assert (flags_o[FL_Z] == (result_o == '0));
  end
endmodule

// File: tb/sized_flag_alu_tb_top.sv
module sized_flag_alu_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic [4:0]  op;
  logic [63:0] dst, src;
  logic [3:0]  size;
  logic        mem;
  logic [3:0]  fl;
  logic [63:0] result;
  logic        we;
  logic [3:0]  fl_out;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  typedef struct {
    logic [63:0] res;
    logic        we;
    logic [3:0]  fl;
    string       tag;
  } exp_t;

  exp_t q[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  sized_flag_alu dut_i (
    .op_i(op), .dst_i(dst), .src_i(src), .size_i(size), .dst_mem_i(mem),
    .flags_i(fl), .result_o(result), .we_o(we), .flags_o(fl_out)
  );

  function automatic exp_t model(input logic [4:0] o, input logic [63:0] d, input logic [63:0] s,
                                 input logic [3:0] sz, input logic m, input logic [3:0] f);
    exp_t e;
    int ka, km, sa, sm;
    logic [63:0] b, r, mask;
    logic cin, hit;
    int szi;
    szi = int'(sz);
    km = (szi > 7) ? 8 : szi + 1;
    ka = m ? km : 8;
    sa = 8 * ka - 1;
    sm = 8 * km - 1;
    e.res = d; e.we = 1'b0; e.fl = f; e.tag = "";
    case (o[2:1])
      2'd0: hit = f[3];
      2'd1: hit = f[1];
      2'd2: hit = f[2];
      default: hit = f[0];
    endcase
    if (o[0]) hit = ~hit;
    mask = (km == 8) ? 64'hFFFF_FFFF_FFFF_FFFF : ((64'h1 << (8 * km)) - 64'h1);
    if (o <= 5'd4) begin
      b   = (o >= 5'd2) ? ~s : s;
      cin = (o == 5'd0) ? 1'b0 : (o == 5'd2 || o == 5'd4) ? 1'b1 : f[1];
      r   = d + b + {63'b0, cin};
      e.res = r;
      e.we  = (o != 5'd4);
      e.fl  = {r[sa], r == 64'h0, r < b, (d[sa] ^ b[sa]) & (d[sa] ^ r[sa])};
    end else if (o <= 5'd10) begin
      case (o)
        5'd5: r = d & s;
        5'd6: r = d | s;
        5'd7: r = d ^ s;
        5'd8: r = d + 64'h1;
        5'd9: r = d - 64'h1;
        default: r = 64'h0 - d;
      endcase
      e.res = r; e.we = 1'b1;
      e.fl  = {r[sa], r == 64'h0, f[1:0]};
    end else if (o == 5'd11 || (o[4:3] == 2'b10 && hit)) begin
      r = s & mask;
      e.res = r; e.we = 1'b1;
      e.fl  = {r[sm], r == 64'h0, f[1:0]};
    end else if (o[4:3] == 2'b11) begin
      e.res = {63'b0, hit}; e.we = 1'b1;
    end
    return e;
  endfunction

  function automatic string req_of(input logic [4:0] o);
    if (o <= 5'd3) return "R2";
    if (o == 5'd4) return "R6";
    if (o <= 5'd10) return "R7";
    if (o == 5'd11) return "R8";
    if (o[4:3] == 2'b10) return "R9";
    if (o[4:3] == 2'b11) return "R11";
    return "R12";
  endfunction

  task automatic send(input logic [4:0] o, input logic [63:0] d, input logic [63:0] s,
                      input logic [3:0] sz, input logic m, input logic [3:0] f, input string tag);
    exp_t e;
    @(posedge clk);
    op = o; dst = d; src = s; size = sz; mem = m; fl = f;
    e = model(o, d, s, sz, m, f);
    e.tag = tag;
    q.push_back(e);
  endtask

  // monitor: one expected item per cycle, compared at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      if (q.size() > 0) begin
        exp_t e;
        e = q.pop_front();
        checks++;
        if (result !== e.res || we !== e.we || fl_out !== e.fl) begin
          failures++;
          $display("FAIL %s: res=%h we=%b fl=%b expected res=%h we=%b fl=%b",
                   e.tag, result, we, fl_out, e.res, e.we, e.fl);
        end
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    op = 5'd0; dst = '0; src = '0; size = '0; mem = 1'b0; fl = 4'h0;
    // R5 idle inputs: zero sum sets Z
    send(5'd0, 64'h0, 64'h0, 4'd0, 1'b0, 4'h0, "R5");
    // R1 memory byte width: sign at bit 7
    send(5'd0, 64'h7F, 64'h01, 4'd0, 1'b1, 4'h0, "R1");
    // R1 register destination ignores size: sign stays at bit 63
    send(5'd0, 64'h7F, 64'h01, 4'd0, 1'b0, 4'h0, "R1");
    // R1 size above 7 capped at 8 bytes
    send(5'd0, 64'h7FFF_FFFF_FFFF_FFFF, 64'h1, 4'd15, 1'b1, 4'h0, "R1");
    // R5 low byte zero but upper bits set: Z clear
    send(5'd0, 64'h1FF, 64'h01, 4'd0, 1'b1, 4'h0, "R5");
    // R3 wraparound carry
    send(5'd0, 64'hFFFF_FFFF_FFFF_FFFF, 64'h1, 4'd0, 1'b0, 4'h0, "R3");
    // R3 carry-in with zero second addend: sum wraps yet C clear
    send(5'd1, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0, 4'd0, 1'b0, 4'h2, "R3");
    // R4 sign difference rule on word width
    send(5'd0, 64'h8000_0000_0000_0000, 64'h0, 4'd0, 1'b0, 4'h0, "R4");
    send(5'd2, 64'h5, 64'h5, 4'd1, 1'b1, 4'h0, "R2");
    send(5'd3, 64'h10, 64'h3, 4'd0, 1'b0, 4'h0, "R2");
    // R6 compare equal: Z, no write
    send(5'd4, 64'h1234, 64'h1234, 4'd0, 1'b0, 4'h0, "R6");
    // R7 logic keeps C and V
    send(5'd5, 64'hF0, 64'h0F, 4'd0, 1'b0, 4'h3, "R7");
    send(5'd10, 64'h1, 64'h0, 4'd1, 1'b1, 4'h1, "R7");
    // R8 move truncation and cap
    send(5'd11, 64'hDEAD_BEEF_0000_1280, 64'hDEAD_BEEF_0000_1280, 4'd0, 1'b0, 4'h3, "R8");
    send(5'd11, 64'h0, 64'h8000_0000_0000_0000, 4'd12, 1'b0, 4'h0, "R8");
    // R9 taken move on Z set (code 4)
    send(5'd20, 64'h55, 64'hAB, 4'd0, 1'b0, 4'h4, "R9");
    // R10 failed move on C set (code 2) with C clear
    send(5'd18, 64'h55, 64'hAB, 4'd7, 1'b0, 4'h9, "R10");
    // R11 set on V clear (code 7)
    send(5'd31, 64'hFF, 64'h0, 4'd0, 1'b0, 4'h1, "R11");
    send(5'd31, 64'hFF, 64'h0, 4'd0, 1'b0, 4'h0, "R11");
    // R12 unassigned opcode
    send(5'd13, 64'hCAFE, 64'h1, 4'd0, 1'b0, 4'hA, "R12");
    for (int i = 0; i < 600; i++) begin
      logic [4:0] o;
      logic [63:0] d, s;
      o = 5'($urandom_range(0, 31));
      d = {$urandom, $urandom};
      s = (i % 7 == 0) ? d : {$urandom, $urandom};
      if (i % 5 == 0) d = d & 64'hFF;
      send(o, d, s, 4'($urandom_range(0, 15)), 1'($urandom_range(0, 1)),
           4'($urandom_range(0, 15)), req_of(o));
    end
    @(posedge clk);
    while (q.size() > 0) @(posedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule